// File: doc/BRIEF.md
# Scheduler Slot-State and Issue-Trace Probe

This block sits beside a multi-slot memory request scheduler and gives software a read-only view of it. It watches a packed vector holding the state code of every scheduler slot, and an issue strobe that carries the tag of each request the scheduler sends out. It keeps a short rolling history of those tags. Software reads one 32-bit word at a time through a small request/response port. The register map describes itself: its first two words give its own dimensions, so one driver routine can walk any build of the probe.

The map has four regions. Word 0 holds the slot count and word 1 holds the history depth. Next come one word per slot, in slot index order. The history words follow, newest tag first. Every address past the end reads as zero.

The read port uses valid/ready on both sides. A request is taken on a rising edge when `rd_req_valid_i` and `rd_req_ready_o` are both high. The response register then shows the word on the next cycle and keeps it until the consumer accepts it. The port takes a new request only when the response register is empty or is being drained in that same cycle. So a stalled consumer pushes back on the requester, and no response is ever lost. The issue strobe is a plain monitor input: the scheduler is never stalled.

Top module: `sched_probe`

## Requirements
- R1: A read of word 0 returns NUM_SLOTS and a read of word 1 returns TRACE_DEPTH, both zero-extended.
- R2: A read of word 2+i (i < NUM_SLOTS) returns the 2-bit state code of slot i, zero-extended, where slot i occupies bits [2i+1:2i] of `slot_state_i`. The codes are 0 empty, 1 pending, 2 processing.
- R3: The unlisted code 3 is returned unchanged, so software can flag it as unexpected.
- R4: A read of word 2+NUM_SLOTS+k (k < TRACE_DEPTH) returns, zero-extended, the tag of the (k+1)-th most recent issue strobe, counted among the strobes seen up to the acceptance edge but not at it.
- R5: Each rising edge with `issue_i` high shifts `issue_tag_i` in at the newest end of the history and drops the oldest tag. An edge without the strobe leaves the history unchanged.
- R6: A read of any word at or above 2+NUM_SLOTS+TRACE_DEPTH returns zero.
- R7: A synchronous active-low reset clears every history entry to zero and empties the response register.
- R8: `rd_req_ready_o` equals (not `rd_rsp_valid_o`) or `rd_rsp_ready_i`. An accepted request raises `rd_rsp_valid_o` on the next cycle. Its data reflects `slot_state_i` in the accepting cycle and the history as it stood before that edge.
- R9: While `rd_rsp_valid_o` is high and `rd_rsp_ready_i` is low, the response valid and data hold steady. The response register empties on an edge where it is drained and no new request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| slot_state_i | input | 2*NUM_SLOTS | Live state codes, slot i in bits [2i+1:2i] |
| issue_i | input | 1 | Issue strobe from the scheduler |
| issue_tag_i | input | TAG_W | Tag of the request issued this cycle |
| rd_req_valid_i | input | 1 | Read request valid |
| rd_req_ready_o | output | 1 | Read request can be taken |
| rd_addr_i | input | ADDR_W | Word address of the read |
| rd_rsp_valid_o | output | 1 | Response word valid |
| rd_rsp_ready_i | input | 1 | Consumer takes the response |
| rd_rsp_data_o | output | DATA_W | Response word |

## Verification
The assertions assume that `rd_req_valid_i` and `rd_addr_i` stay free of X whenever reset is released. They also assume that `issue_tag_i` is defined whenever `issue_i` is high. The bench meets both by driving every input to a known value from time zero and changing inputs only just after falling edges. The stimulus includes stalls of the response consumer and issue strobes in the same cycle as an accepted read. Both stay inside the handshake rules above, so the hold and shift properties are exercised under legal traffic.

// File: rtl/probe_pkg.sv
package probe_pkg;
  localparam int unsigned STATE_W   = 2;
  localparam int unsigned HDR_WORDS = 2;

  typedef enum logic [STATE_W-1:0] {
    SLOT_EMPTY   = 2'd0,
    SLOT_PENDING = 2'd1,
    SLOT_BUSY    = 2'd2,
    SLOT_BAD     = 2'd3
  } slot_state_e;
endpackage

// File: rtl/probe_tag_history.sv
module probe_tag_history #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned TAG_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   shift_i,
  input  logic [TAG_W-1:0]       tag_i,
  output logic [DEPTH*TAG_W-1:0] hist_o
);
  logic [TAG_W-1:0] entry_q [DEPTH];

  generate
    for (genvar k = 0; k < DEPTH; k++) begin : g_entry
      if (k == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (!rst_n)       entry_q[0] <= '0;
          else if (shift_i) entry_q[0] <= tag_i;
        end
      end else begin : g_tail
        always_ff @(posedge clk) begin
          if (!rst_n)       entry_q[k] <= '0;
          else if (shift_i) entry_q[k] <= entry_q[k-1];
        end
      end
      assign hist_o[k*TAG_W +: TAG_W] = entry_q[k];
    end
  endgenerate

  // R5
  newest_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_i |=> hist_o[TAG_W-1:0] == $past(tag_i));
  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_i && rst_n) |=> $stable(hist_o));
endmodule

// File: rtl/probe_word_mux.sv
module probe_word_mux
  import probe_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned DEPTH     = 4,
  parameter int unsigned TAG_W     = 8,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32
) (
  input  logic [NUM_SLOTS*STATE_W-1:0] slots_i,
  input  logic [DEPTH*TAG_W-1:0]       hist_i,
  input  logic [ADDR_W-1:0]            addr_i,
  output logic [DATA_W-1:0]            word_o
);
  localparam int unsigned SLOT_BASE = HDR_WORDS;
  localparam int unsigned HIST_BASE = SLOT_BASE + NUM_SLOTS;
  localparam int unsigned TOTAL     = HIST_BASE + DEPTH;

  logic [DATA_W-1:0] words [TOTAL];

  assign words[0] = DATA_W'(NUM_SLOTS);
  assign words[1] = DATA_W'(DEPTH);

  generate
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      assign words[SLOT_BASE+s] = DATA_W'(slots_i[s*STATE_W +: STATE_W]);
    end
    for (genvar k = 0; k < DEPTH; k++) begin : g_hist
      assign words[HIST_BASE+k] = DATA_W'(hist_i[k*TAG_W +: TAG_W]);
    end
  endgenerate

  always_comb begin
    word_o = '0;
    for (int w = 0; w < TOTAL; w++) begin
      if (addr_i == ADDR_W'(w)) word_o = words[w];
    end
  end
endmodule

// File: rtl/probe_rsp_reg.sv
module probe_rsp_reg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              drain_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= word_i;
    end else if (drain_i) begin
      valid_o <= 1'b0;
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !drain_i && !load_i) |=> (valid_o && $stable(data_o)));
  // R8
  load_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> valid_o);
endmodule

// File: rtl/sched_probe.sv
module sched_probe
  import probe_pkg::*;
#(
  parameter int unsigned NUM_SLOTS   = 4,
  parameter int unsigned TRACE_DEPTH = 4,
  parameter int unsigned TAG_W       = 8,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_SLOTS*STATE_W-1:0] slot_state_i,
  input  logic                         issue_i,
  input  logic [TAG_W-1:0]             issue_tag_i,
  input  logic                         rd_req_valid_i,
  output logic                         rd_req_ready_o,
  input  logic [ADDR_W-1:0]            rd_addr_i,
  output logic                         rd_rsp_valid_o,
  input  logic                         rd_rsp_ready_i,
  output logic [DATA_W-1:0]            rd_rsp_data_o
);
  localparam int unsigned MAP_WORDS = HDR_WORDS + NUM_SLOTS + TRACE_DEPTH;

  logic [TRACE_DEPTH*TAG_W-1:0] hist;
  logic [DATA_W-1:0]            word;
  logic                         accept;

  assign rd_req_ready_o = !rd_rsp_valid_o || rd_rsp_ready_i;
  assign accept         = rd_req_valid_i && rd_req_ready_o;

  probe_tag_history #(.DEPTH(TRACE_DEPTH), .TAG_W(TAG_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .shift_i(issue_i), .tag_i(issue_tag_i),
    .hist_o(hist));

  probe_word_mux #(.NUM_SLOTS(NUM_SLOTS), .DEPTH(TRACE_DEPTH), .TAG_W(TAG_W),
                   .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
    .slots_i(slot_state_i), .hist_i(hist), .addr_i(rd_addr_i), .word_o(word));

  probe_rsp_reg #(.DATA_W(DATA_W)) u_rsp (
    .clk(clk), .rst_n(rst_n), .load_i(accept), .word_i(word),
    .drain_i(rd_rsp_ready_i), .valid_o(rd_rsp_valid_o), .data_o(rd_rsp_data_o));

  // R6
  past_end_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (rd_addr_i >= ADDR_W'(MAP_WORDS))) |=> rd_rsp_data_o == '0);
  // R1
  slot_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && rd_addr_i == '0) |=> rd_rsp_data_o == DATA_W'(NUM_SLOTS));
  // R8
  no_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rsp_valid_o && !rd_rsp_ready_i) |-> !rd_req_ready_o);
endmodule

// File: tb/tb_sched_probe.sv
module tb_sched_probe;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4, TD = 4, TW = 8, AW = 8, DW = 32;
  localparam int MAPW = 2 + NS + TD;

  logic clk = 0, rst_n = 0;
  logic [NS*2-1:0] slot_state = '0;
  logic issue = 0;
  logic [TW-1:0] tag = '0;
  logic req_valid = 0, rsp_ready = 1;
  logic [AW-1:0] addr = '0;
  logic req_ready, rsp_valid;
  logic [DW-1:0] rsp_data;

  int checks = 0, errors = 0, cycles = 0;

  // model state
  int  m_hist [TD];
  int  m_issued = 0;
  bit  m_valid = 0;
  int  m_data = 0;
  string m_req = "R7";

  always #(CLK_PERIOD/2) clk = ~clk;

  sched_probe #(.NUM_SLOTS(NS), .TRACE_DEPTH(TD), .TAG_W(TW), .ADDR_W(AW),
                .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .slot_state_i(slot_state), .issue_i(issue),
    .issue_tag_i(tag), .rd_req_valid_i(req_valid), .rd_req_ready_o(req_ready),
    .rd_addr_i(addr), .rd_rsp_valid_o(rsp_valid), .rd_rsp_ready_i(rsp_ready),
    .rd_rsp_data_o(rsp_data));

  function automatic int lookup(int a);
    if (a == 0) return NS;
    if (a == 1) return TD;
    if (a < 2 + NS) return int'(slot_state[(a-2)*2 +: 2]);
    if (a < MAPW) return m_hist[a-2-NS];
    return 0;
  endfunction

  function automatic string tag_of(int a);
    if (a < 2) return "R1";
    if (a < 2 + NS) return (slot_state[(a-2)*2 +: 2] == 2'd3) ? "R3" : "R2";
    if (a < MAPW) return (m_issued == 0) ? "R7" : "R4 R5";
    return "R6";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < TD; k++) m_hist[k] = 0;
      m_valid = 0; m_data = 0; m_issued = 0;
    end else begin
      bit acc;
      acc = req_valid && (!m_valid || rsp_ready);
      if (acc) begin
        m_data = lookup(int'(addr)); m_req = tag_of(int'(addr)); m_valid = 1;
      end else if (m_valid && rsp_ready) m_valid = 0;
      if (issue) begin
        for (int k = TD-1; k > 0; k--) m_hist[k] = m_hist[k-1];
        m_hist[0] = int'(tag);
        m_issued++;
      end
    end
  end

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    chk(rst_n ? "R8" : "R7", int'(rsp_valid), int'(m_valid));
    chk("R8", int'(req_ready), int'(!m_valid || rsp_ready));
    if (rsp_valid && m_valid) chk(m_req, int'(rsp_data), m_data);
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic rd(int a);
    req_valid = 1; addr = AW'(a); step(); req_valid = 0; step();
  endtask

  task automatic iss(int t);
    issue = 1; tag = TW'(t); step(); issue = 0;
  endtask

  initial begin
    step(3);
    rst_n = 1; step();
    // R7 history zero after reset, R1 header
    for (int a = 0; a < MAPW; a++) rd(a);
    // R2 state patterns, R3 code 3
    slot_state = {2'd2, 2'd1, 2'd0, 2'd3};
    for (int a = 2; a < 2 + NS; a++) rd(a);
    slot_state = {2'd3, 2'd0, 2'd2, 2'd1};
    for (int a = 2; a < 2 + NS; a++) rd(a);
    // R5 shifting, R4 order
    for (int t = 1; t <= 6; t++) iss(8'h10 + t);
    step(2);
    for (int a = 2 + NS; a < MAPW; a++) rd(a);
    // R6 past end
    rd(MAPW); rd(MAPW + 1); rd(255);
    // R8 issue at same edge as accept: old history seen
    req_valid = 1; addr = AW'(2 + NS); issue = 1; tag = 8'hA5; step();
    req_valid = 0; issue = 0; step();
    rd(2 + NS); rd(3 + NS);
    // R9 back-pressure: stalled response holds, new request waits
    rsp_ready = 0; req_valid = 1; addr = 8'd0; step();
    addr = 8'd1; slot_state = '1; step(4);
    rsp_ready = 1; step(); req_valid = 0; step(2);
    // streaming reads back-to-back with drain
    req_valid = 1;
    for (int a = 0; a < MAPW + 2; a++) begin addr = AW'(a); step(); end
    req_valid = 0; step(2);
    // R7 reset mid-run clears history
    rst_n = 0; step(2); rst_n = 1; step();
    for (int a = 2 + NS; a < MAPW; a++) rd(a);
    step(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule